// File: doc/BRIEF.md
# NAND Hamming ECC Parity Accumulator

This block sits beside a NAND data path and watches the bytes moving to or from the flash device. For every byte of a sector it folds the byte's bits into a set of even and odd Hamming parities. Column parities come from the bit position inside a byte, and line parities come from the byte's index in the sector. When the programmed number of bytes has gone past, the two parity halves are packed into one result word and held for software or a correction stage to read.

Software sets the engine up with three register writes: the sector length, the chip select and bus width it follows, and a control write that clears the sums and arms the single result slot. The engine counts only strobes tagged with the configured chip select. A 16-bit bus is split into two bytes, low byte first. The parity is not inverted, so an erased page of all-ones data gives a zero code.

Top module: `nand_ecc_acc`

## Requirements
- R1: After reset, res_o is 0 and the engine is disabled, so data strobes change nothing until it has been configured and armed.
- R2: reg_sel_i picks the register a write lands in: 0 is control, 1 is size, 2 is config. In config, bit 0 enables the engine, bits [3:1] hold the chip select to follow, and bit 7 selects the 16-bit (1) or 8-bit (0) column width.
- R3: A control write with bit 8 set zeroes the parity sums and the byte count and reopens the sector. Bits [3:0] of every control write select the result slot. Only slot 1 exists; with any other value, and with 0 in particular, the engine stays idle and captures nothing.
- R4: Size register bits [29:22] hold (sector bytes / 2) - 1, so a sector is 2 to 512 bytes long, counted in 16-bit units.
- R5: If byte k holds a one at bit b, form the 12-bit address a = k*8 + b. For every address bit j, that one toggles odd parity bit j when a[j] is 1 and even parity bit j when a[j] is 0. The even bits sit in result [11:0] and the odd bits in [27:16], with bit j going to position j of its half.
- R6: In 8-bit mode, each accepted strobe carries one byte, taken from dat_i[7:0]; dat_i[15:8] is ignored.
- R7: In 16-bit mode, each accepted strobe carries two bytes at consecutive indices: dat_i[7:0] first, then dat_i[15:8].
- R8: A strobe whose dat_cs_i differs from the configured chip select is ignored.
- R9: The result is latched on the strobe that completes the sector. Until then res_o keeps its previous value. After that, strobes are ignored until the next clear.
- R10: The code is not inverted: a full sector of 0xFF bytes yields a result of 0.
- R11: Result bits [15:12] and [31:28] always read 0.
- R12: While the engine is disabled, strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 control, 1 size, 2 config |
| reg_wdata_i | input | 32 | Register write data |
| dat_vld_i | input | 1 | Data strobe, one bus transfer per cycle |
| dat_cs_i | input | 3 | Chip-select tag of the transfer |
| dat_i | input | 16 | Transfer data |
| res_o | output | 32 | Latched parity result |

## Verification
The bench uses a single set bit at a known byte and bit position. A design that swapped the even and odd halves, or that misaligned the line index against the column index, would give a different fixed constant. It feeds the same sector once on the 8-bit path and once on the 16-bit path. Getting the byte order or the index step wrong shows up as a mismatch between the two, and driving junk on the upper lane in 8-bit mode catches a design that lets those bits leak in. It also covers:
- Off-target chip selects mixed into a sector, which would corrupt a result that accepts them.
- An all-0xFF sector of maximum length, which would not come out as zero if the code were inverted.
- Strobes after completion, with the engine disabled, and with slot 0 selected, each of which must leave the held result untouched.
- A clear in the middle of a sector, which must discard the partial sums.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_SIZE = 2'd1,
    REG_CFG  = 2'd2
  } reg_sel_e;

  localparam int CLR_BIT   = 8;
  localparam int SLOT_W    = 4;
  localparam logic [SLOT_W-1:0] SLOT_CODE = 4'd1;
  localparam int SIZE_LSB  = 22;
  localparam int EN_BIT    = 0;
  localparam int CS_LSB    = 1;
  localparam int WIDE_BIT  = 7;
  localparam int ODD_LSB   = 16;
  localparam int COL_W     = 3;
endpackage

// File: rtl/nand_ecc_regs.sv
module nand_ecc_regs
  import nand_ecc_pkg::*;
#(
  parameter int SZ_W = 8,
  parameter int CS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [1:0]      sel_i,
  input  logic [31:0]     wdata_i,
  output logic            clr_o,
  output logic            armed_o,
  output logic            en_o,
  output logic            wide_o,
  output logic [CS_W-1:0] cs_o,
  output logic [SZ_W-1:0] size_o
);
  logic wr_ctrl, wr_size, wr_cfg;
  logic unused_wdata;

  assign wr_ctrl = we_i && (sel_i == REG_CTRL);
  assign wr_size = we_i && (sel_i == REG_SIZE);
  assign wr_cfg  = we_i && (sel_i == REG_CFG);
  assign clr_o   = wr_ctrl && wdata_i[CLR_BIT];
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_o <= 1'b0;
      en_o    <= 1'b0;
      wide_o  <= 1'b0;
      cs_o    <= '0;
      size_o  <= '0;
    end else begin
      if (wr_ctrl) armed_o <= (wdata_i[SLOT_W-1:0] == SLOT_CODE);
      if (wr_size) size_o  <= wdata_i[SIZE_LSB +: SZ_W];
      if (wr_cfg) begin
        en_o   <= wdata_i[EN_BIT];
        wide_o <= wdata_i[WIDE_BIT];
        cs_o   <= wdata_i[CS_LSB +: CS_W];
      end
    end
  end
endmodule

// File: rtl/nand_ecc_byte_par.sv
module nand_ecc_byte_par
  import nand_ecc_pkg::*;
#(
  parameter int LINE_W = 9,
  localparam int PAR_W = COL_W + LINE_W
) (
  input  logic [7:0]        byte_i,
  input  logic [LINE_W-1:0] idx_i,
  output logic [PAR_W-1:0]  ev_o,
  output logic [PAR_W-1:0]  od_o
);
  logic [COL_W-1:0]  col_ev, col_od;
  logic [LINE_W-1:0] line_ev, line_od;
  logic              byte_par;

  function automatic logic [7:0] col_mask(input int j);
    logic [7:0] m;
    for (int b = 0; b < 8; b++) m[b] = (((b >> j) & 1) == 0);
    return m;
  endfunction

  always_comb begin
    for (int j = 0; j < COL_W; j++) begin
      col_ev[j] = ^(byte_i & col_mask(j));
      col_od[j] = ^(byte_i & ~col_mask(j));
    end
  end

  assign byte_par = ^byte_i;

  for (genvar j = 0; j < LINE_W; j++) begin : g_line
    assign line_ev[j] = byte_par & ~idx_i[j];
    assign line_od[j] = byte_par &  idx_i[j];
  end

  assign ev_o = {line_ev, col_ev};
  assign od_o = {line_od, col_od};
endmodule

// File: rtl/nand_ecc_core.sv
module nand_ecc_core
  import nand_ecc_pkg::*;
#(
  parameter int SZ_W = 8,
  parameter int CS_W = 3,
  localparam int LINE_W = SZ_W + 1,
  localparam int PAR_W  = COL_W + LINE_W,
  localparam int CNT_W  = LINE_W + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            armed_i,
  input  logic            en_i,
  input  logic            wide_i,
  input  logic [CS_W-1:0] cs_cfg_i,
  input  logic [SZ_W-1:0] size_i,
  input  logic            vld_i,
  input  logic [CS_W-1:0] cs_i,
  input  logic [15:0]     dat_i,
  output logic [31:0]     res_o
);
  logic [PAR_W-1:0]  ev_q, od_q, lo_ev, lo_od, hi_ev, hi_od, ev_nx, od_nx;
  logic [CNT_W-1:0]  cnt_q, cnt_nx, total, step;
  logic [LINE_W-1:0] idx_lo, idx_hi;
  logic              done_q, take, last;
  logic [31:0]       res_q, res_nx;

  assign idx_lo = cnt_q[LINE_W-1:0];
  assign idx_hi = idx_lo + 1'b1;

  nand_ecc_byte_par #(.LINE_W(LINE_W)) u_lo (
    .byte_i(dat_i[7:0]), .idx_i(idx_lo), .ev_o(lo_ev), .od_o(lo_od)
  );
  nand_ecc_byte_par #(.LINE_W(LINE_W)) u_hi (
    .byte_i(dat_i[15:8]), .idx_i(idx_hi), .ev_o(hi_ev), .od_o(hi_od)
  );

  // Sector bytes = 2 * (field + 1)
  assign total  = CNT_W'({size_i, 1'b0}) + CNT_W'(2);
  assign step   = wide_i ? CNT_W'(2) : CNT_W'(1);
  assign cnt_nx = cnt_q + step;
  assign last   = (cnt_nx >= total);
  assign take   = vld_i && en_i && armed_i && (cs_i == cs_cfg_i) && !done_q;

  assign ev_nx = ev_q ^ lo_ev ^ (wide_i ? hi_ev : '0);
  assign od_nx = od_q ^ lo_od ^ (wide_i ? hi_od : '0);

  always_comb begin
    res_nx = '0;
    res_nx[PAR_W-1:0]           = ev_nx;
    res_nx[ODD_LSB +: PAR_W]    = od_nx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_q   <= '0;
      od_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      res_q  <= '0;
    end else if (clr_i) begin
      ev_q   <= '0;
      od_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (take) begin
      ev_q  <= ev_nx;
      od_q  <= od_nx;
      cnt_q <= cnt_nx;
      if (last) begin
        done_q <= 1'b1;
        res_q  <= res_nx;
      end
    end
  end

  assign res_o = res_q;

  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && !done_q && ev_q == '0 && od_q == '0));
  p_idle_slot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_i && !clr_i) |=> ($stable(ev_q) && $stable(od_q) && $stable(cnt_q)));
  p_cs_filter_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && cs_i != cs_cfg_i && !clr_i) |=> ($stable(cnt_q) && $stable(res_q)));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !clr_i) |=> (done_q && $stable(res_q) && $stable(cnt_q)));
  p_disabled_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> ($stable(cnt_q) && $stable(res_q)));
  p_pad_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_q[15:12] == 4'd0 && res_q[31:28] == 4'd0));
endmodule

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc
  import nand_ecc_pkg::*;
#(
  parameter int SZ_W = 8,
  parameter int CS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [1:0]      reg_sel_i,
  input  logic [31:0]     reg_wdata_i,
  input  logic            dat_vld_i,
  input  logic [CS_W-1:0] dat_cs_i,
  input  logic [15:0]     dat_i,
  output logic [31:0]     res_o
);
  logic            clr, armed, en, wide;
  logic [CS_W-1:0] cs_cfg;
  logic [SZ_W-1:0] size;

  nand_ecc_regs #(.SZ_W(SZ_W), .CS_W(CS_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .sel_i(reg_sel_i),
    .wdata_i(reg_wdata_i), .clr_o(clr), .armed_o(armed), .en_o(en),
    .wide_o(wide), .cs_o(cs_cfg), .size_o(size)
  );

  nand_ecc_core #(.SZ_W(SZ_W), .CS_W(CS_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .armed_i(armed), .en_i(en),
    .wide_i(wide), .cs_cfg_i(cs_cfg), .size_i(size), .vld_i(dat_vld_i),
    .cs_i(dat_cs_i), .dat_i(dat_i), .res_o(res_o)
  );
endmodule

// File: tb/tb_nand_ecc_acc.sv
module tb_nand_ecc_acc;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_sel_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic        dat_vld_i = 1'b0;
  logic [2:0]  dat_cs_i = '0;
  logic [15:0] dat_i = '0;
  logic [31:0] res_o;

  int errors = 0;
  int checks = 0;
  logic [7:0]  bytes_q [0:511];
  logic [31:0] held;

  nand_ecc_acc dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .dat_vld_i(dat_vld_i), .dat_cs_i(dat_cs_i),
    .dat_i(dat_i), .res_o(res_o)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = val;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic set_cfg(input logic en, input logic [2:0] cs, input logic wide);
    reg_wr(2'd2, {24'd0, wide, 3'd0, cs, en});
  endtask
  task automatic set_size(input int words);
    reg_wr(2'd1, 32'(words - 1) << 22);
  endtask
  task automatic set_ctrl(input logic clr, input logic [3:0] slot);
    reg_wr(2'd0, {23'd0, clr, 4'd0, slot});
  endtask

  task automatic push(input logic [2:0] cs, input logic [15:0] d);
    @(negedge clk);
    dat_vld_i = 1'b1; dat_cs_i = cs; dat_i = d;
    @(negedge clk);
    dat_vld_i = 1'b0;
  endtask

  // Independent model: per set bit, address = k*8+b split over its bits
  function automatic logic [31:0] calc(input int n);
    logic [11:0] ev = '0, od = '0;
    for (int k = 0; k < n; k++)
      for (int b = 0; b < 8; b++)
        if (bytes_q[k][b]) begin
          logic [11:0] a = 12'(k * 8 + b);
          for (int j = 0; j < 12; j++)
            if (a[j]) od[j] = ~od[j]; else ev[j] = ~ev[j];
        end
    return {4'd0, od, 4'd0, ev};
  endfunction

  task automatic feed(input int n, input logic wide, input logic [7:0] junk);
    if (wide) for (int i = 0; i < n; i += 2) push(3'd2, {bytes_q[i+1], bytes_q[i]});
    else      for (int i = 0; i < n; i++)    push(3'd2, {junk, bytes_q[i]});
  endtask

  task automatic fill(input int seed, input int mul);
    for (int i = 0; i < 512; i++) bytes_q[i] = 8'(i * mul + seed);
  endtask

  task automatic t_reset;
    chk("R1 reset result", res_o, 32'd0);
    fill(3, 7);
    feed(16, 1'b0, 8'h00);
    chk("R1 strobes ignored before setup", res_o, 32'd0);
  endtask

  task automatic t_byte8;
    set_cfg(1'b1, 3'd2, 1'b0);
    set_size(8);
    set_ctrl(1'b1, 4'd1);
    fill(11, 37);
    feed(15, 1'b0, 8'hA5);
    chk("R9 result held before sector end", res_o, 32'd0);
    push(3'd2, {8'h5A, bytes_q[15]});
    chk("R6 R5 8-bit sector", res_o, calc(16));
    chk("R11 pad bits zero", res_o & 32'hF000_F000, 32'd0);
    held = res_o;
  endtask

  task automatic t_word16;
    set_cfg(1'b1, 3'd2, 1'b1);
    set_ctrl(1'b1, 4'd1);
    fill(0, 1);
    feed(16, 1'b1, 8'h00);
    chk("R7 16-bit ramp", res_o, calc(16));
    fill(11, 37);
    set_ctrl(1'b1, 4'd1);
    feed(16, 1'b1, 8'h00);
    chk("R7 16-bit matches 8-bit", res_o, held);
  endtask

  task automatic t_onebit;
    set_cfg(1'b1, 3'd2, 1'b0);
    set_ctrl(1'b1, 4'd1);
    for (int i = 0; i < 512; i++) bytes_q[i] = 8'h00;
    bytes_q[5] = 8'h08;
    feed(16, 1'b0, 8'hFF);
    chk("R5 single bit at byte 5 bit 3", res_o, 32'h002B_0FD4);
  endtask

  task automatic t_cs_filter;
    set_ctrl(1'b1, 4'd1);
    fill(77, 13);
    for (int i = 0; i < 16; i++) begin
      push(3'd5, 16'hC3C3 ^ 16'(i));
      push(3'd2, {8'h00, bytes_q[i]});
    end
    chk("R8 other chip select ignored", res_o, calc(16));
    held = res_o;
  endtask

  task automatic t_stop;
    for (int i = 0; i < 6; i++) push(3'd2, 16'h00FF - 16'(i));
    chk("R9 strobes after completion ignored", res_o, held);
    set_ctrl(1'b1, 4'd1);
    fill(200, 3);
    feed(16, 1'b0, 8'h00);
    chk("R9 new sector after clear", res_o, calc(16));
    held = res_o;
  endtask

  task automatic t_slot0;
    set_ctrl(1'b1, 4'd0);
    fill(9, 29);
    feed(16, 1'b0, 8'h00);
    chk("R3 slot 0 captures nothing", res_o, held);
    set_ctrl(1'b0, 4'd3);
    feed(16, 1'b0, 8'h00);
    chk("R3 slot 3 captures nothing", res_o, held);
    set_ctrl(1'b0, 4'd1);
    feed(16, 1'b0, 8'h00);
    chk("R3 armed without clear after idle", res_o, calc(16));
    held = res_o;
  endtask

  task automatic t_disabled;
    set_cfg(1'b0, 3'd2, 1'b0);
    set_ctrl(1'b1, 4'd1);
    fill(41, 5);
    feed(16, 1'b0, 8'h00);
    chk("R12 disabled engine ignores data", res_o, held);
    set_cfg(1'b1, 3'd2, 1'b0);
    fill(60, 17);
    feed(16, 1'b0, 8'h00);
    chk("R12 R2 enable then sector", res_o, calc(16));
  endtask

  task automatic t_midclear;
    set_ctrl(1'b1, 4'd1);
    for (int i = 0; i < 5; i++) push(3'd2, 16'h0081 + 16'(i));
    set_ctrl(1'b1, 4'd1);
    fill(123, 19);
    feed(16, 1'b0, 8'h00);
    chk("R3 clear discards partial sums", res_o, calc(16));
  endtask

  task automatic t_size_min;
    set_size(1);
    set_ctrl(1'b1, 4'd1);
    bytes_q[0] = 8'h96; bytes_q[1] = 8'h3C;
    feed(2, 1'b0, 8'h00);
    chk("R4 two-byte sector", res_o, calc(2));
  endtask

  task automatic t_erased;
    set_cfg(1'b1, 3'd2, 1'b1);
    set_size(256);
    set_ctrl(1'b1, 4'd1);
    for (int i = 0; i < 512; i++) bytes_q[i] = 8'h01;
    feed(512, 1'b1, 8'h00);
    chk("R4 full 512-byte sector", res_o, calc(512));
    set_ctrl(1'b1, 4'd1);
    for (int i = 0; i < 512; i++) bytes_q[i] = 8'hFF;
    feed(512, 1'b1, 8'h00);
    chk("R10 erased page gives zero code", res_o, 32'd0);
  endtask

  initial begin
    #100_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset;
    t_byte8;
    t_word16;
    t_onebit;
    t_cs_filter;
    t_stop;
    t_slot0;
    t_disabled;
    t_midclear;
    t_size_min;
    t_erased;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule